// File: doc/BRIEF.md
# Cache Line Flush Unit

The block carries out one cache-line maintenance request at a time for a write-back data cache and the instruction cache beside it. A request arrives on a valid/ready handshake and carries a qualifying predicate, a byte address with its not-a-thing (NaT) flag, the current privilege level and a form select. Form 0 removes the line from the whole hierarchy. Form 1 only brings the instruction cache into step with the data cache. The block screens the request for faults. Outside privilege 0 it asks a permission lookup port whether a one-byte read of the address is allowed. Protection keys are never consulted.

When the request may proceed, the block probes the data cache for the line. A dirty resident line is first written to memory through a handshake port. The block then issues the maintenance pulses: data-line invalidate, data-line clean and instruction-line invalidate. These pulses share one cycle with a done pulse that carries a 2-bit fault code. Lines are 32 bytes by default, so the low five address bits do not select the line. The caches and memory sit outside the block and are reached only through these ports.

Top module: `line_flush_unit`

## Requirements
- R1: `req_ready` is high only while no request is held. From the accepting edge until the cycle after `done`, it stays low, so only one flush is in flight.
- R2: When the predicate is 0, the request ends with `done` and fault code 0. This holds whatever the NaT flag, permission or cache state is. There is no permission lookup, no memory write and no maintenance pulse.
- R3: When the predicate is 1 and the NaT flag is 1, `done` carries fault code 1 (NaT). There is no permission lookup, no memory write and no maintenance pulse.
- R4: The line address is the byte address shifted right by log2 of the line size (5 by default). `probe_line`, `mem_wr_line` and `op_line` all carry it, so changing the low five address bits changes none of them. `perm_addr` carries the full byte address.
- R5: At privilege 0 no permission lookup is made (`perm_req` stays low), and the flush proceeds even when `perm_ok` is 0.
- R6: At privileges 1 to 3, `perm_req` is raised for one cycle with the byte address. If `perm_ok` is 0 in that cycle, `done` carries fault code 2 (access), with no memory write and no maintenance pulse.
- R7: Form 0 on a resident dirty line writes the line data once to `mem_wr_line`. Only afterwards does the block pulse `dc_inv` and `ic_inv` together with `done`.
- R8: Form 0 on a resident clean line pulses `dc_inv` and `ic_inv` with `done` and makes no memory write.
- R9: Form 1 never pulses `dc_inv`. On a resident dirty line it writes the line back once and then pulses `dc_clean` and `ic_inv`. On a resident clean line it pulses only `ic_inv`.
- R10: A line that is not resident (`probe_hit` 0) causes no memory write and no data-cache pulse. `ic_inv` is still pulsed in both forms.
- R11: While `mem_wr_valid` is high and `mem_wr_ready` is low, the write stays offered with unchanged line and data.
- R12: `done` is a one-cycle pulse. Fault codes are 0 none, 1 NaT and 2 access; code 3 never occurs. Maintenance pulses appear only in a `done` cycle that carries code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_pred | input | 1 | Qualifying predicate |
| req_nat | input | 1 | NaT flag of the address operand |
| req_form | input | 1 | 0 invalidate line, 1 instruction-coherent |
| req_priv | input | 2 | Current privilege level |
| req_addr | input | ADDR_W | Byte address |
| perm_req | output | 1 | Permission lookup strobe (one-byte read) |
| perm_addr | output | ADDR_W | Byte address being checked |
| perm_ok | input | 1 | Read permitted, sampled while perm_req is high |
| probe_line | output | ADDR_W-5 | Line address presented to the data cache |
| probe_hit | input | 1 | Line resident |
| probe_dirty | input | 1 | Resident line is dirty |
| probe_data | input | DATA_W | Resident line contents |
| mem_wr_valid | output | 1 | Write-back offered |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_line | output | ADDR_W-5 | Write-back line address |
| mem_wr_data | output | DATA_W | Write-back data |
| dc_inv | output | 1 | Invalidate data line |
| dc_clean | output | 1 | Mark data line clean |
| ic_inv | output | 1 | Invalidate instruction line |
| op_line | output | ADDR_W-5 | Line address for maintenance pulses |
| done | output | 1 | Request finished |
| done_fault | output | 2 | Fault code, valid with done |

## Verification
The instruction-cache invalidate and the data-line clean or invalidate share one cycle, and that cycle is also the `done` cycle. The invalidate must never coincide with a write-back still pending. The bench sets this up with dirty resident lines in both forms, holding `mem_wr_ready` low for random stretches of zero to three cycles. Every cycle it records which pulses appear, and it fails any pulse that appears without `done`, any `done` seen while the write is still offered, and any pulse set that differs from the expected set for the form and line state.

// File: rtl/lfu_pkg.sv
package lfu_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_NAT    = 2'd1,
        FLT_ACCESS = 2'd2
    } fault_e;

    typedef enum logic {
        FORM_INVAL = 1'b0,
        FORM_ICOH  = 1'b1
    } form_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WB,
        ST_FINISH
    } state_e;

    typedef struct packed {
        logic wb;
        logic dinv;
        logic dclean;
        logic iinv;
    } plan_t;

    function automatic logic needs_perm(input logic [1:0] priv);
        return priv != 2'd0;
    endfunction

endpackage

// File: rtl/lfu_fault_check.sv
module lfu_fault_check
    import lfu_pkg::*;
(
    input  logic       pred,
    input  logic       nat,
    input  logic [1:0] priv,
    input  logic       perm_ok,
    output logic       perm_need,
    output logic       proceed,
    output fault_e     fault
);
    always_comb begin
        perm_need = pred && !nat && needs_perm(priv);
        fault     = FLT_NONE;
        if (pred && nat)
            fault = FLT_NAT;
        else if (perm_need && !perm_ok)
            fault = FLT_ACCESS;
        proceed = pred && (fault == FLT_NONE);
    end
endmodule

// File: rtl/lfu_op_plan.sv
module lfu_op_plan
    import lfu_pkg::*;
(
    input  form_e form,
    input  logic  hit,
    input  logic  dirty,
    output plan_t plan
);
    always_comb begin
        plan.wb     = hit && dirty;
        plan.dinv   = (form == FORM_INVAL) && hit;
        plan.dclean = (form == FORM_ICOH) && hit && dirty;
        plan.iinv   = 1'b1;
    end
endmodule

// File: rtl/lfu_wb_port.sv
module lfu_wb_port #(
    parameter int LINE_W = 27,
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LINE_W-1:0] line_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [LINE_W-1:0] wr_line,
    output logic [DATA_W-1:0] wr_data,
    output logic              fire
);
    assign fire = wr_valid && wr_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_line  <= '0;
            wr_data  <= '0;
        end else if (start) begin
            wr_valid <= 1'b1;
            wr_line  <= line_in;
            wr_data  <= data_in;
        end else if (fire) begin
            wr_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/line_flush_unit.sv
module line_flush_unit
    import lfu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int DATA_W     = 256,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_pred,
    input  logic              req_nat,
    input  logic              req_form,
    input  logic [1:0]        req_priv,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              perm_req,
    output logic [ADDR_W-1:0] perm_addr,
    input  logic              perm_ok,
    output logic [LINE_W-1:0] probe_line,
    input  logic              probe_hit,
    input  logic              probe_dirty,
    input  logic [DATA_W-1:0] probe_data,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [LINE_W-1:0] mem_wr_line,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              dc_inv,
    output logic              dc_clean,
    output logic              ic_inv,
    output logic [LINE_W-1:0] op_line,
    output logic              done,
    output logic [1:0]        done_fault
);
    state_e            state;
    logic              pred_q, nat_q;
    form_e             form_q;
    logic [1:0]        priv_q;
    logic [ADDR_W-1:0] addr_q;
    plan_t             plan_q, plan_c;
    fault_e            fault_q, fault_c;
    logic              perm_need, proceed, wb_start, wb_fire;

    lfu_fault_check u_fault (
        .pred      (pred_q),
        .nat       (nat_q),
        .priv      (priv_q),
        .perm_ok   (perm_ok),
        .perm_need (perm_need),
        .proceed   (proceed),
        .fault     (fault_c)
    );

    lfu_op_plan u_plan (
        .form  (form_q),
        .hit   (probe_hit),
        .dirty (probe_dirty),
        .plan  (plan_c)
    );

    assign wb_start = (state == ST_CHECK) && proceed && plan_c.wb;

    lfu_wb_port #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_wb (
        .clk      (clk),
        .rst      (rst),
        .start    (wb_start),
        .line_in  (addr_q[ADDR_W-1:OFF_W]),
        .data_in  (probe_data),
        .wr_valid (mem_wr_valid),
        .wr_ready (mem_wr_ready),
        .wr_line  (mem_wr_line),
        .wr_data  (mem_wr_data),
        .fire     (wb_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pred_q  <= 1'b0;
            nat_q   <= 1'b0;
            form_q  <= FORM_INVAL;
            priv_q  <= 2'd0;
            addr_q  <= '0;
            plan_q  <= '0;
            fault_q <= FLT_NONE;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    pred_q <= req_pred;
                    nat_q  <= req_nat;
                    form_q <= form_e'(req_form);
                    priv_q <= req_priv;
                    addr_q <= req_addr;
                    state  <= ST_CHECK;
                end
                ST_CHECK: begin
                    fault_q <= fault_c;
                    if (proceed) begin
                        plan_q <= plan_c;
                        state  <= plan_c.wb ? ST_WB : ST_FINISH;
                    end else begin
                        plan_q <= '0;
                        state  <= ST_FINISH;
                    end
                end
                ST_WB:     if (wb_fire) state <= ST_FINISH;
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state == ST_IDLE);
    assign perm_req   = (state == ST_CHECK) && perm_need;
    assign perm_addr  = addr_q;
    assign probe_line = addr_q[ADDR_W-1:OFF_W];
    assign op_line    = addr_q[ADDR_W-1:OFF_W];
    assign done       = (state == ST_FINISH);
    assign done_fault = done ? fault_q : FLT_NONE;
    assign dc_inv     = done && plan_q.dinv;
    assign dc_clean   = done && plan_q.dclean;
    assign ic_inv     = done && plan_q.iinv;
endmodule

// File: rtl/line_flush_unit_chk.sv
module line_flush_unit_chk #(
    parameter int LINE_W = 27,
    parameter int DATA_W = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              perm_req,
    input logic              mem_wr_valid,
    input logic              mem_wr_ready,
    input logic [LINE_W-1:0] mem_wr_line,
    input logic [DATA_W-1:0] mem_wr_data,
    input logic              dc_inv,
    input logic              dc_clean,
    input logic              ic_inv,
    input logic              done,
    input logic [1:0]        done_fault
);
    // R1
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (done || perm_req || mem_wr_valid) |-> !req_ready);

    // R11
    wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_line) && $stable(mem_wr_data)));

    // R7
    wb_before_done_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> !done);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    fault_code_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_fault != 2'd3));

    // R12
    ops_in_done_chk: assert property (@(posedge clk) disable iff (rst)
        (dc_inv || dc_clean || ic_inv) |-> (done && done_fault == 2'd0));

    // R9
    inv_clean_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(dc_inv && dc_clean));
endmodule

bind line_flush_unit line_flush_unit_chk #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .perm_req     (perm_req),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_line  (mem_wr_line),
    .mem_wr_data  (mem_wr_data),
    .dc_inv       (dc_inv),
    .dc_clean     (dc_clean),
    .ic_inv       (ic_inv),
    .done         (done),
    .done_fault   (done_fault)
);

// File: tb/line_flush_unit_test.sv
module line_flush_unit_test;
    localparam int AW = 32;
    localparam int DW = 256;
    localparam int LW = AW - 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_pred = 0, req_nat = 0, req_form = 0;
    logic [1:0] req_priv = 0;
    logic [AW-1:0] req_addr = 0;
    logic perm_ok = 0, probe_hit = 0, probe_dirty = 0, mem_wr_ready = 0;
    logic [DW-1:0] probe_data = 0;
    logic req_ready, perm_req, mem_wr_valid, dc_inv, dc_clean, ic_inv, done;
    logic [AW-1:0] perm_addr;
    logic [LW-1:0] probe_line, mem_wr_line, op_line;
    logic [DW-1:0] mem_wr_data;
    logic [1:0] done_fault;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    line_flush_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_pred(req_pred), .req_nat(req_nat), .req_form(req_form),
        .req_priv(req_priv), .req_addr(req_addr), .perm_req(perm_req),
        .perm_addr(perm_addr), .perm_ok(perm_ok), .probe_line(probe_line),
        .probe_hit(probe_hit), .probe_dirty(probe_dirty), .probe_data(probe_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_line(mem_wr_line), .mem_wr_data(mem_wr_data),
        .dc_inv(dc_inv), .dc_clean(dc_clean), .ic_inv(ic_inv),
        .op_line(op_line), .done(done), .done_fault(done_fault)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_fault(input bit pred, nat, input logic [1:0] priv, input bit pok);
        if (!pred) return 2'd0;
        if (nat) return 2'd1;
        if (priv != 0 && !pok) return 2'd2;
        return 2'd0;
    endfunction

    task automatic run_txn(input bit pred, nat, form, input logic [1:0] priv,
                           input logic [AW-1:0] addr, input bit hit, dirty, pok,
                           input logic [DW-1:0] data, input int delay);
        logic [1:0] ef = exp_fault(pred, nat, priv, pok);
        bit go = pred && (ef == 2'd0);
        bit e_wb = go && hit && dirty;
        bit e_dinv = go && !form && hit;
        bit e_dcln = go && form && hit && dirty;
        bit e_iinv = go;
        bit e_perm = pred && !nat && (priv != 0);
        bit seen_done = 0, seen_perm = 0, stray = 0, busy_ready = 0;
        bit g_dinv = 0, g_dcln = 0, g_iinv = 0;
        logic [1:0] g_fault = 0;
        logic [AW-1:0] g_paddr = 0;
        logic [LW-1:0] g_wline = 0, g_oline = 0, g_probe = 0;
        logic [DW-1:0] g_wdata = 0;
        int nwr = 0, wcnt = 0;

        @(negedge clk);
        req_pred = pred; req_nat = nat; req_form = form; req_priv = priv;
        req_addr = addr; probe_hit = hit; probe_dirty = dirty; perm_ok = pok;
        probe_data = data;
        check(req_ready == 1'b1, "R1", "ready when idle", DW'(req_ready), 1);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n < 40; n++) begin
            if (perm_req) begin seen_perm = 1; g_paddr = perm_addr; end
            if (mem_wr_valid) begin
                if (wcnt == delay) begin
                    mem_wr_ready = 1'b1; nwr++;
                    g_wline = mem_wr_line; g_wdata = mem_wr_data;
                end else begin
                    wcnt++; mem_wr_ready = 1'b0;
                end
            end else mem_wr_ready = 1'b0;
            if ((dc_inv || dc_clean || ic_inv) && !done) stray = 1;
            if (req_ready) busy_ready = 1;
            if (done) begin
                seen_done = 1; g_fault = done_fault;
                g_dinv = dc_inv; g_dcln = dc_clean; g_iinv = ic_inv;
                g_oline = op_line; g_probe = probe_line;
                break;
            end
            @(negedge clk);
        end
        mem_wr_ready = 1'b0;
        check(seen_done, "R12", "done seen", DW'(seen_done), 1);
        check(!busy_ready, "R1", "ready low while busy", DW'(busy_ready), 0);
        check(!stray, "R12", "pulse outside done", DW'(stray), 0);
        check(g_fault == ef, ef == 1 ? "R3" : (ef == 2 ? "R6" : "R2"), "fault code", DW'(g_fault), DW'(ef));
        check(seen_perm == e_perm, priv == 0 ? "R5" : "R6", "perm lookup", DW'(seen_perm), DW'(e_perm));
        if (e_perm) check(g_paddr == addr, "R4", "perm byte addr", DW'(g_paddr), DW'(addr));
        check(nwr == int'(e_wb), hit ? "R7" : "R10", "writeback count", DW'(nwr), DW'(e_wb));
        if (e_wb && nwr == 1) begin
            check(g_wline == addr[AW-1:5], "R4", "writeback line", DW'(g_wline), DW'(addr[AW-1:5]));
            check(g_wdata == data, "R7", "writeback data", g_wdata, data);
        end
        check(g_dinv == e_dinv, form ? "R9" : "R8", "dc_inv", DW'(g_dinv), DW'(e_dinv));
        check(g_dcln == e_dcln, "R9", "dc_clean", DW'(g_dcln), DW'(e_dcln));
        check(g_iinv == e_iinv, "R10", "ic_inv", DW'(g_iinv), DW'(e_iinv));
        check(g_probe == addr[AW-1:5], "R4", "probe line", DW'(g_probe), DW'(addr[AW-1:5]));
        if (go) check(g_oline == addr[AW-1:5], "R4", "op line", DW'(g_oline), DW'(addr[AW-1:5]));
        @(negedge clk);
        check(!done, "R12", "done one cycle", DW'(done), 0);
        check(req_ready, "R1", "ready after done", DW'(req_ready), 1);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check(req_ready && !done && !mem_wr_valid && !perm_req, "R1", "reset state",
              DW'({req_ready, done, mem_wr_valid, perm_req}), DW'(4'b1000));
        d = {8{32'hCAFE_0123}};
        // R2 predicate off, even with NaT and dirty line
        run_txn(0, 1, 0, 2'd3, 32'h1000_0040, 1, 1, 0, d, 0);
        // R3 NaT fault
        run_txn(1, 1, 1, 2'd2, 32'h1000_0060, 1, 1, 1, d, 0);
        // R5 privilege 0 ignores a denying permission port
        run_txn(1, 0, 0, 2'd0, 32'h2000_001F, 1, 0, 0, d, 0);
        // R6 access fault
        run_txn(1, 0, 0, 2'd1, 32'h2000_0020, 1, 1, 0, d, 0);
        // R7 dirty invalidate with stalled memory, R11
        run_txn(1, 0, 0, 2'd3, 32'h3000_00A5, 1, 1, 1, d, 3);
        // R4 same line from the other end of it
        run_txn(1, 0, 0, 2'd3, 32'h3000_00BF, 1, 1, 1, ~d, 1);
        // R8 clean invalidate
        run_txn(1, 0, 0, 2'd1, 32'h4000_0000, 1, 0, 1, d, 0);
        // R9 coherent dirty and clean
        run_txn(1, 0, 1, 2'd2, 32'h5000_0100, 1, 1, 1, d, 2);
        run_txn(1, 0, 1, 2'd0, 32'h5000_0120, 1, 0, 0, d, 0);
        // R10 not resident, both forms, dirty flag set on a miss
        run_txn(1, 0, 0, 2'd0, 32'h6000_0000, 0, 1, 1, d, 0);
        run_txn(1, 0, 1, 2'd3, 32'h6000_0020, 0, 0, 1, d, 0);
        for (int i = 0; i < 400; i++) begin
            d = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            run_txn(($urandom % 8) != 0, ($urandom % 8) == 0, 1'($urandom),
                    2'($urandom), $urandom, 1'($urandom), 1'($urandom),
                    ($urandom % 4) != 0, d, int'($urandom % 4));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule